// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Character Queue

This block turns bytes written by a processor into an asynchronous serial bit stream. Every serial bit is timed by an external enable pulse that arrives sixteen times per bit period, so the block needs no divisor of its own. Each frame is a low start bit, five to eight data bits sent least-significant first, an optional even or odd parity bit, and a high stop period of one, one and a half or two bit times. A break control holds the line low for as long as it is set.

Written bytes wait in a queue in front of the shift register. With queue mode on the queue holds sixteen bytes. With queue mode off it behaves as a single holding register. A clear input empties the queue without disturbing a character already being shifted out, and any change of the mode input empties it too. A ready output, meant for a DMA controller, shows whether another write will be taken. Two status flags show an empty queue and a fully idle transmitter.

The framer is a five-state machine. IDLE moves to START in the clock after it finds the queue non-empty, popping one byte. START moves to DATA after 16 enable pulses. DATA stays for one bit per 16 pulses and, after the last data bit, moves to PARITY if parity is on, or to STOP if it is off. PARITY moves to STOP after 16 pulses. STOP returns to IDLE after 16, 24 or 32 pulses.

Top module: `async_tx`

## Requirements
- R1: After reset, txd is high and hold_empty, shift_empty and tx_ready are all 1.
- R2: A frame is a low start bit followed by char_len+5 data bits, least significant first (char_len 0=5, 1=6, 2=7, 3=8 bits). Every bit lasts 16 baud_tick pulses. Each written and accepted byte produces exactly one frame, in write order.
- R3: When parity_en is 1, one parity bit follows the data bits. With parity_even=1 it makes the count of ones over the data and parity bits even. With parity_even=0 it makes that count odd. When parity_en is 0 no parity bit is sent.
- R4: The stop period is high and lasts 16 pulses when stop_long=0, 24 pulses when stop_long=1 and char_len=0, and 32 pulses when stop_long=1 with any other length. The next queued frame starts within one clock after the stop period ends.
- R5: With fifo_mode=1 the queue holds up to 16 bytes besides the one in the shift register. tx_ready is 0 exactly when the queue is full, and a write while it is full is ignored.
- R6: With fifo_mode=0 the queue holds one byte. tx_ready equals hold_empty, and a write while the byte is held is ignored.
- R7: hold_empty is 1 when the queue is empty. shift_empty is 1 only when the queue is empty and no frame is in progress.
- R8: A pulse on fifo_clear empties the queue within one clock. A frame already started finishes unchanged.
- R9: Any change of fifo_mode empties the queue within one clock after the change.
- R10: While break_ctl is 1, txd is low. When break_ctl is cleared on an idle line, txd returns high and no frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Enable pulse, 16 per bit time |
| wr_en | input | 1 | Write strobe for wr_data |
| wr_data | input | 8 | Byte to send |
| fifo_mode | input | 1 | 1 = 16-byte queue, 0 = single holding register |
| fifo_clear | input | 1 | Empties the queue |
| char_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Adds a parity bit |
| parity_even | input | 1 | 1 = even parity, 0 = odd |
| stop_long | input | 1 | 1.5 or 2 stop bits instead of 1 |
| break_ctl | input | 1 | Forces txd low |
| txd | output | 1 | Serial output, idles high |
| tx_ready | output | 1 | Another write will be accepted |
| hold_empty | output | 1 | Queue is empty |
| shift_empty | output | 1 | Queue empty and framer idle |

## Verification
The bench aims at the stop-length corner: the 1.5-bit stop that only 5-bit characters get. It measures each frame's length in enable pulses, so a design that used 24 pulses for every length, or never used 24, gives the wrong frame time. It fills the queue and the single holding register past capacity. A design that overwrote an entry or let the count wrap would then send an extra frame or a wrong byte. It also clears the queue and switches the mode while a character sits in the shift register, so that a design which aborted that character, or kept stale entries, shows a missing or unexpected frame. Parity is checked in both senses over every length, which catches an inverted sense or a parity taken over the unused upper bits.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_t;

    typedef struct packed {
        logic [1:0] len;       // data bits minus five
        logic       par_on;
        logic       par_even;
        logic       stop_long;
    } line_cfg_t;

    localparam int SUBTICKS = 16;

    // last sub-tick index of the stop period: 15, 23 or 31
    function automatic logic [4:0] stop_last(input line_cfg_t c);
        if (!c.stop_long)        return 5'd15;
        else if (c.len == 2'd0)  return 5'd23;
        else                     return 5'd31;
    endfunction

    // mask of the data bits that are transmitted
    function automatic logic [7:0] data_mask(input logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction

endpackage

// File: rtl/async_tx_queue.sv
module async_tx_queue #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count, cap;
    logic              mode_q, flush, do_wr, do_rd;

    assign cap   = fifo_mode ? CW'(DEPTH) : CW'(1);
    assign flush = clear || (fifo_mode != mode_q);
    assign empty = (count == '0);
    assign full  = (count >= cap);
    assign do_wr = wr_en && !full && !flush;
    assign do_rd = rd_en && !empty && !flush;
    assign rd_data = mem[rd_ptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            mode_q <= 1'b0;
        end else begin
            mode_q <= fifo_mode;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                count  <= '0;
            end else begin
                if (do_wr) wr_ptr <= nxt(wr_ptr);
                if (do_rd) rd_ptr <= nxt(rd_ptr);
                if (do_wr && !do_rd)      count <= count + CW'(1);
                else if (do_rd && !do_wr) count <= count - CW'(1);
            end
        end
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R5
    full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en && !flush) |=> (count == $past(count)));

    // R9
    mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode != mode_q) |=> empty);

endmodule

// File: rtl/async_tx_framer.sv
module async_tx_framer
    import async_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      q_empty,
    input  logic [7:0] q_data,
    input  line_cfg_t cfg,
    input  logic      brk,
    output logic      pop,
    output logic      txd,
    output logic      busy
);

    tx_state_t  state, state_n;
    logic [4:0] sub_cnt;
    logic [2:0] bit_idx;
    logic [7:0] shreg;
    logic       par_q, par_calc;
    logic [4:0] stop_end;
    logic       bit_done, stop_done, unit_done;

    always_comb begin
        stop_end  = stop_last(cfg);
        bit_done  = tick && (sub_cnt == 5'(SUBTICKS - 1));
        stop_done = tick && (sub_cnt == stop_end);
        unit_done = (state == ST_STOP) ? stop_done : bit_done;
        par_calc  = (^(q_data & data_mask(cfg.len))) ^ ~cfg.par_even;
        pop       = (state == ST_IDLE) && !q_empty;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (!q_empty) state_n = ST_START;
            ST_START:  if (bit_done) state_n = ST_DATA;
            ST_DATA:   if (bit_done && bit_idx == (3'd4 + {1'b0, cfg.len}))
                           state_n = cfg.par_on ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_done) state_n = ST_STOP;
            ST_STOP:   if (stop_done) state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sub_cnt <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_q   <= 1'b0;
        end else begin
            state <= state_n;
            if (pop) begin
                shreg   <= q_data;
                par_q   <= par_calc;
                sub_cnt <= '0;
                bit_idx <= '0;
            end else if (tick && state != ST_IDLE) begin
                sub_cnt <= unit_done ? 5'd0 : sub_cnt + 5'd1;
                if (state == ST_DATA && bit_done) begin
                    shreg   <= shreg >> 1;
                    bit_idx <= bit_idx + 3'd1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy = (state != ST_IDLE);
        unique case (state)
            ST_IDLE:   txd = 1'b1;
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_q;
            ST_STOP:   txd = 1'b1;
            default:   txd = 1'b1;
        endcase
        if (brk) txd = 1'b0;
    end

    // R2
    load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (state == ST_START && sub_cnt == 5'd0));

    // R4
    stop_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP) |-> (sub_cnt <= stop_end));

    // R2
    bit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_STOP && state != ST_IDLE) |-> (sub_cnt < 5'(SUBTICKS)));

endmodule

// File: rtl/async_tx.sv
module async_tx
    import async_tx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       fifo_mode,
    input  logic       fifo_clear,
    input  logic [1:0] char_len,
    input  logic       parity_en,
    input  logic       parity_even,
    input  logic       stop_long,
    input  logic       break_ctl,
    output logic       txd,
    output logic       tx_ready,
    output logic       hold_empty,
    output logic       shift_empty
);

    line_cfg_t  cfg;
    logic       q_empty, q_full, pop, busy;
    logic [7:0] q_data;

    assign cfg = '{len: char_len, par_on: parity_en,
                   par_even: parity_even, stop_long: stop_long};

    async_tx_queue #(.DATA_W(8), .DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (fifo_mode),
        .clear     (fifo_clear),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (pop),
        .rd_data   (q_data),
        .empty     (q_empty),
        .full      (q_full)
    );

    async_tx_framer u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .q_empty (q_empty),
        .q_data  (q_data),
        .cfg     (cfg),
        .brk     (break_ctl),
        .pop     (pop),
        .txd     (txd),
        .busy    (busy)
    );

    assign tx_ready    = !q_full;
    assign hold_empty  = q_empty;
    assign shift_empty = q_empty && !busy;

    // R8
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear |=> hold_empty);

    // R6
    single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && !hold_empty) |-> !tx_ready);

    // R7
    busy_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!txd && !break_ctl) |-> !shift_empty);

endmodule

// File: tb/async_tx_bench.sv
`timescale 1ns/1ps
module async_tx_bench;

    typedef struct packed {
        logic [7:0] d;
        logic [1:0] len;
        logic       pe;
        logic       pev;
        logic       sl;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
    logic wr_en = 1'b0, fifo_mode = 1'b1, fifo_clear = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] char_len = 2'd3;
    logic parity_en = 1'b0, parity_even = 1'b0, stop_long = 1'b0, break_ctl = 1'b0;
    logic txd, tx_ready, hold_empty, shift_empty;

    exp_t exp_q[$];
    int   n_checks = 0, n_fail = 0;
    bit   tick_on = 1'b1, done = 1'b0, mon_active = 1'b0;

    always #2.5 clk = ~clk;

    async_tx u_async_tx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .fifo_mode(fifo_mode), .fifo_clear(fifo_clear),
        .char_len(char_len), .parity_en(parity_en), .parity_even(parity_even),
        .stop_long(stop_long), .break_ctl(break_ctl), .txd(txd),
        .tx_ready(tx_ready), .hold_empty(hold_empty), .shift_empty(shift_empty)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // enable pulse every 4 clocks
    initial begin
        int div = 0;
        forever begin
            @(posedge clk); #1;
            baud_tick = tick_on && (div == 3);
            div = (div + 1) % 4;
        end
    end

    task automatic write_byte(input logic [7:0] d, input bit expect_it);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = d;
        if (expect_it) exp_q.push_back('{d: d, len: char_len, pe: parity_en,
                                         pev: parity_even, sl: stop_long});
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic clocks(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_idle();
        int guard = 0;
        do begin
            @(posedge clk); #2;
            guard++;
        end while (!(shift_empty && !mon_active && exp_q.size() == 0) && guard < 40000);
        check(exp_q.size() == 0, "R2", "frames still expected", exp_q.size(), 0);
    endtask

    // ---------------- monitor ----------------
    exp_t cur;
    int   cnt, nb, pb, tot, nxt_s, last_s;
    logic [10:0] bits;
    logic prev_txd = 1'b1;

    task automatic begin_frame();
        if (exp_q.size() == 0) begin
            check(1'b0, "R2", "unexpected frame", 1, 0);
            cur = '0;
        end else begin
            cur = exp_q.pop_front();
        end
        nb     = 5 + int'(cur.len);
        pb     = cur.pe ? 1 : 0;
        last_s = 1 + nb + pb;
        tot    = 16 * (1 + nb + pb) + (!cur.sl ? 16 : (cur.len == 2'd0 ? 24 : 32));
        cnt    = 0;
        nxt_s  = 0;
        bits   = '0;
        mon_active = 1'b1;
    endtask

    task automatic judge_bits();
        logic [7:0] rx, m, e;
        rx = '0;
        for (int i = 0; i < nb; i++) rx[i] = bits[i + 1];
        m = 8'hFF >> (8 - nb);
        e = cur.d & m;
        check(bits[0] == 1'b0, "R2", "start bit level", int'(bits[0]), 0);
        check(rx == e, "R2", "data bits", int'(rx), int'(e));
        if (cur.pe) begin
            logic pexp;
            pexp = (^e) ^ ~cur.pev;
            check(bits[nb + 1] == pexp, "R3", "parity bit", int'(bits[nb + 1]), int'(pexp));
        end
        check(bits[last_s] == 1'b1, "R4", "stop bit level", int'(bits[last_s]), 1);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mon_active = 1'b0;
                prev_txd   = 1'b1;
            end else begin
                if (mon_active) begin
                    if (nxt_s <= last_s && cnt == 8 + 16 * nxt_s) begin
                        bits[nxt_s] = txd;
                        nxt_s++;
                        if (nxt_s > last_s) judge_bits();
                    end
                    if (shift_empty || (nxt_s > last_s && !txd)) begin
                        check(cnt == tot, "R4", "frame length in ticks", cnt, tot);
                        mon_active = 1'b0;
                        if (!txd && !break_ctl) begin_frame();
                    end
                end else if (prev_txd && !txd && !break_ctl) begin
                    begin_frame();
                end
                if (mon_active && baud_tick) cnt++;
                prev_txd = txd;
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "R2", "watchdog expired", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        clocks(5);
        @(posedge clk); #1 rst_n = 1'b1;
        clocks(3);
        // R1 reset state
        check(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
        check(hold_empty == 1'b1, "R1", "hold_empty after reset", int'(hold_empty), 1);
        check(shift_empty == 1'b1, "R1", "shift_empty after reset", int'(shift_empty), 1);
        check(tx_ready == 1'b1, "R1", "tx_ready after reset", int'(tx_ready), 1);

        // R2 R3 R4: every length, parity mode and stop setting
        for (int len = 0; len < 4; len++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int sl = 0; sl < 2; sl++) begin
                    logic [7:0] d;
                    char_len    = 2'(len);
                    parity_en   = (pm != 0);
                    parity_even = (pm == 1);
                    stop_long   = sl[0];
                    d = 8'(len * 53 + pm * 29 + sl * 101 + 7);
                    write_byte(d, 1'b1);
                    write_byte(d ^ 8'hFF, 1'b1);
                    wait_idle();
                end
            end
        end

        // R5: fill the queue, overflow write ignored
        char_len = 2'd3; parity_en = 1'b1; parity_even = 1'b0; stop_long = 1'b0;
        tick_on = 1'b0;
        clocks(2);
        for (int k = 0; k < 17; k++) write_byte(8'(8'h30 + k), 1'b1);
        clocks(1);
        check(tx_ready == 1'b0, "R5", "tx_ready with full queue", int'(tx_ready), 0);
        check(hold_empty == 1'b0, "R7", "hold_empty with full queue", int'(hold_empty), 0);
        write_byte(8'hEE, 1'b0);
        tick_on = 1'b1;
        wait_idle();
        check(tx_ready == 1'b1, "R5", "tx_ready after drain", int'(tx_ready), 1);

        // R6: single holding register
        fifo_mode = 1'b0;
        clocks(3);
        tick_on = 1'b0;
        write_byte(8'h11, 1'b1);
        clocks(3);
        check(tx_ready == 1'b1, "R6", "tx_ready with empty holder", int'(tx_ready), 1);
        check(hold_empty == 1'b1, "R7", "hold_empty while shifting", int'(hold_empty), 1);
        check(shift_empty == 1'b0, "R7", "shift_empty while shifting", int'(shift_empty), 0);
        write_byte(8'h22, 1'b1);
        clocks(1);
        check(tx_ready == 1'b0, "R6", "tx_ready with holder used", int'(tx_ready), 0);
        check(hold_empty == 1'b0, "R6", "hold_empty with holder used", int'(hold_empty), 0);
        write_byte(8'h33, 1'b0);
        tick_on = 1'b1;
        wait_idle();

        // R8: clear keeps the character in the shifter
        fifo_mode = 1'b1;
        clocks(3);
        tick_on = 1'b0;
        write_byte(8'h41, 1'b1);
        write_byte(8'h42, 1'b0);
        write_byte(8'h43, 1'b0);
        write_byte(8'h44, 1'b0);
        check(hold_empty == 1'b0, "R8", "hold_empty before clear", int'(hold_empty), 0);
        @(posedge clk); #1 fifo_clear = 1'b1;
        @(posedge clk); #1 fifo_clear = 1'b0;
        clocks(1);
        check(hold_empty == 1'b1, "R8", "hold_empty after clear", int'(hold_empty), 1);
        check(shift_empty == 1'b0, "R8", "shifter kept after clear", int'(shift_empty), 0);
        tick_on = 1'b1;
        wait_idle();

        // R9: mode change flushes the queue
        tick_on = 1'b0;
        write_byte(8'h51, 1'b1);
        write_byte(8'h52, 1'b0);
        write_byte(8'h53, 1'b0);
        check(hold_empty == 1'b0, "R9", "hold_empty before mode change", int'(hold_empty), 0);
        @(posedge clk); #1 fifo_mode = 1'b0;
        clocks(2);
        check(hold_empty == 1'b1, "R9", "hold_empty after mode change", int'(hold_empty), 1);
        tick_on = 1'b1;
        wait_idle();
        fifo_mode = 1'b1;
        clocks(3);

        // R10: break on an idle line
        @(posedge clk); #1 break_ctl = 1'b1;
        clocks(2);
        check(txd == 1'b0, "R10", "txd during break", int'(txd), 0);
        clocks(40);
        check(txd == 1'b0, "R10", "txd held during break", int'(txd), 0);
        @(posedge clk); #1 break_ctl = 1'b0;
        clocks(2);
        check(txd == 1'b1, "R10", "txd after break", int'(txd), 1);
        clocks(100);
        check(shift_empty == 1'b1, "R10", "no frame after break", int'(shift_empty), 1);
        check(!mon_active, "R10", "monitor saw no frame", int'(mon_active), 0);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule